// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises a processor's service routine by watching a kick line. A kick is a falling edge on that line. After the watchdog has been armed, the first kick only has to arrive before an upper cycle limit. Every later kick has to land strictly inside a window: after a lower limit and before the upper limit, both counted from the previous accepted kick. A kick that comes too early and a kick that never comes are both faults. A fault drives an active-low fault output, which then stays low.

The watchdog is live only while its enable input is high and the supervisor's reset input is low. Whenever either condition fails, the watchdog drops all its state, ignores the kick line and releases the fault output. Each time the watchdog becomes live again, it first waits a fixed setup period during which kicks are ignored. It then starts over in first-kick mode. The two window bounds and the setup length are parameters given in clock cycles.

Timing convention. The window restarts at the clock edge where first-kick mode is entered or a kick is accepted. The elapsed count `c` of a later edge is the number of clock edges strictly between the restart edge and that edge. A kick is sampled at the first edge where the line reads low after reading high at the previous edge.

Top module: `winwdg_top`

## Requirements
- R1: Only a falling edge counts as a kick: the line sampled high at one edge and low at the next. A rising edge, or a line held low, does not restart the window.
- R2: In first-kick mode, any kick with elapsed count `c < HI_CYC` is accepted. If no kick arrives, the fault asserts at the edge where `c == HI_CYC`.
- R3: After the first kick, a kick with `LO_CYC < c < HI_CYC` is accepted and the fault output stays high.
- R4: A kick in window mode with `c <= LO_CYC` asserts the fault. This includes a kick exactly on the lower bound.
- R5: In window mode, the fault asserts at the edge where `c == HI_CYC`. This happens both when no kick arrives and when a kick lands exactly on that edge.
- R6: While `enable_i` is low, the fault output is high from the edge after the low level is sampled, and kicks are ignored.
- R7: After the watchdog becomes live, the first `SETUP_CYC + 1` active edges ignore kicks. First-kick mode is entered on edge `SETUP_CYC + 1`.
- R8: While `sup_rst_i` is high, the watchdog behaves exactly as when disabled: the fault output is released and kicks are ignored.
- R9: Once asserted, the fault stays asserted for as long as the watchdog remains live, whatever the kick line does.
- R10: `fault_drive_o` is high exactly when `fault_n_o` is driven low.
- R11: Synchronous reset `rst` releases the fault output, clears `fault_drive_o` and disarms the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Kick line; a falling edge is a kick |
| enable_i | input | 1 | Watchdog enable, high to run |
| sup_rst_i | input | 1 | Supervisor reset active, high disables the watchdog |
| fault_n_o | output | 1 | Active-low fault flag |
| fault_drive_o | output | 1 | High when the fault output is actively driven low |

## Verification
Both outputs come straight from a state register. A kick or a timeout that is decided at edge N is therefore visible in the half cycle after edge N. A disable or a supervisor reset sampled at edge N releases the fault after that same edge. The bench drives inputs on falling clock edges and compares the outputs on every falling edge against a cycle model built from the elapsed-count convention. Directed kicks are timed by waiting until the model's count equals the target value before lowering the line. The following falling edge then carries the verdict and is checked against a literal expected value.

// File: rtl/winwdg_pkg.sv
package winwdg_pkg;

    typedef enum logic [1:0] {
        WIN_OFF   = 2'd0,
        WIN_FIRST = 2'd1,
        WIN_OPEN  = 2'd2,
        WIN_TRIP  = 2'd3
    } win_state_e;

    typedef struct packed {
        logic fall;
        logic live;
    } wd_ctl_t;

    function automatic int unsigned cnt_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    function automatic logic kick_ok(input logic first, input logic [31:0] c,
                                     input logic [31:0] lo, input logic [31:0] hi);
        if (first) return c < hi;
        return (c > lo) && (c < hi);
    endfunction

endpackage

// File: rtl/winwdg_fall.sv
module winwdg_fall (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sig_i;
    end

    assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/winwdg_arm.sv
module winwdg_arm #(
    parameter int unsigned SETUP_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic sup_rst_i,
    output logic live_o
);
    localparam int unsigned SW = winwdg_pkg::cnt_bits(SETUP_CYC);

    logic          active;
    logic          done_q;
    logic [SW-1:0] scnt_q;

    assign active = enable_i & ~sup_rst_i;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            scnt_q <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (scnt_q == SW'(SETUP_CYC - 1)) done_q <= 1'b1;
            scnt_q <= scnt_q + SW'(1);
        end
    end

    assign live_o = active & done_q;
endmodule

// File: rtl/winwdg_window.sv
module winwdg_window
    import winwdg_pkg::*;
#(
    parameter int unsigned LO_CYC = 20,
    parameter int unsigned HI_CYC = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  wd_ctl_t    ctl_i,
    output win_state_e state_o
);
    localparam int unsigned CW = cnt_bits(HI_CYC);

    win_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          good;

    assign good = kick_ok(state_q == WIN_FIRST, 32'(cnt_q), 32'(LO_CYC), 32'(HI_CYC));

    always_ff @(posedge clk) begin
        if (rst || !ctl_i.live) begin
            state_q <= WIN_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                WIN_OFF: begin
                    state_q <= WIN_FIRST;
                    cnt_q   <= '0;
                end
                WIN_FIRST, WIN_OPEN: begin
                    if (ctl_i.fall) begin
                        if (good) begin
                            state_q <= WIN_OPEN;
                            cnt_q   <= '0;
                        end else begin
                            state_q <= WIN_TRIP;
                        end
                    end else if (cnt_q == CW'(HI_CYC)) begin
                        state_q <= WIN_TRIP;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                WIN_TRIP: state_q <= WIN_TRIP;
                default:  state_q <= WIN_OFF;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/winwdg_top.sv
module winwdg_top
    import winwdg_pkg::*;
#(
    parameter int unsigned LO_CYC    = 20,
    parameter int unsigned HI_CYC    = 60,
    parameter int unsigned SETUP_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    input  logic enable_i,
    input  logic sup_rst_i,
    output logic fault_n_o,
    output logic fault_drive_o
);
    wd_ctl_t    ctl;
    win_state_e state;

    winwdg_fall u_fall (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (kick_i),
        .fall_o (ctl.fall)
    );

    winwdg_arm #(.SETUP_CYC(SETUP_CYC)) u_arm (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable_i),
        .sup_rst_i (sup_rst_i),
        .live_o    (ctl.live)
    );

    winwdg_window #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_win (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .state_o (state)
    );

    assign fault_n_o     = (state != WIN_TRIP);
    assign fault_drive_o = (state == WIN_TRIP);
endmodule

// File: rtl/winwdg_chk.sv
module winwdg_chk #(
    parameter int unsigned SETUP_CYC = 8
) (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic sup_rst_i,
    input logic fault_n_o,
    input logic fault_drive_o
);
    logic [15:0] act_cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable_i || sup_rst_i) act_cnt <= '0;
        else if (act_cnt != 16'hFFFF)      act_cnt <= act_cnt + 16'd1;
    end

    assert_reset_release_R11: assert property (@(posedge clk)
        rst |=> (fault_n_o && !fault_drive_o));

    assert_disable_release_R6: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> fault_n_o);

    assert_suprst_release_R8: assert property (@(posedge clk) disable iff (rst)
        sup_rst_i |=> fault_n_o);

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!fault_n_o && enable_i && !sup_rst_i) |=> !fault_n_o);

    assert_no_fault_in_setup_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n_o) |-> (32'(act_cnt) > SETUP_CYC + 1));

    assert_status_match_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n_o) |-> $rose(fault_drive_o));
endmodule

bind winwdg_top winwdg_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable_i      (enable_i),
    .sup_rst_i     (sup_rst_i),
    .fault_n_o     (fault_n_o),
    .fault_drive_o (fault_drive_o)
);

// File: tb/sim_winwdg_top.sv
`timescale 1ns/1ps
module sim_winwdg_top;
    localparam int LO = 20;
    localparam int HI = 60;
    localparam int SU = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick = 1'b1;
    logic en = 1'b0;
    logic sup = 1'b0;
    logic fault_n, fault_drv;

    int checks = 0;
    int errors = 0;
    string cur = "R11";
    bit started = 0;

    always #5 clk = ~clk;

    winwdg_top #(.LO_CYC(LO), .HI_CYC(HI), .SETUP_CYC(SU)) u0 (
        .clk(clk), .rst(rst), .kick_i(kick), .enable_i(en), .sup_rst_i(sup),
        .fault_n_o(fault_n), .fault_drive_o(fault_drv)
    );

    // reference model: 0 off, 2 first-kick, 3 window, 4 tripped
    int m_ph = 0;
    int m_n = 0;
    int m_c = 0;
    bit m_prev = 1;

    function automatic bit exp_ok(bit first, int c);
        if (first) return c < HI;
        return (c > LO) && (c < HI);
    endfunction

    always @(posedge clk) begin
        bit fall;
        started = 1;
        if (rst) begin
            m_ph = 0; m_n = 0; m_c = 0; m_prev = 1;
        end else begin
            fall = m_prev && !kick;
            m_prev = kick;
            if (!en || sup) begin
                m_ph = 0; m_n = 0; m_c = 0;
            end else begin
                if (m_n < SU + 2) m_n++;
                if (m_ph == 0) begin
                    if (m_n == SU + 1) begin m_ph = 2; m_c = 0; end
                end else if (m_ph == 2 || m_ph == 3) begin
                    if (fall) begin
                        if (exp_ok(m_ph == 2, m_c)) begin m_ph = 3; m_c = 0; end
                        else m_ph = 4;
                    end else if (m_c == HI) m_ph = 4;
                    else m_c++;
                end
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(fault_n, !(m_ph == 4), cur, "model fault_n_o");
            chk(fault_drv, (m_ph == 4), "R10", "model fault_drive_o");
        end
    end

    task automatic wait_count(input int ph, input int c);
        forever begin
            @(negedge clk);
            if (m_ph == ph && m_c == c) break;
        end
    endtask

    task automatic kick_at(input int ph, input int c, input logic exp_n, input string req);
        wait_count(ph, c);
        kick = 1'b0;
        @(negedge clk);
        chk(fault_n, exp_n, req, "fault_n_o after kick");
        kick = 1'b1;
    endtask

    task automatic toggle_for(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            kick = ~kick;
        end
        kick = 1'b1;
    endtask

    task automatic rearm;
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(fault_n, 1'b1, "R11", "reset fault_n_o");
        chk(fault_drv, 1'b0, "R11", "reset fault_drive_o");
        rst = 1'b0;

        // R7: kick during setup ignored, so a kick at c=0 is still a first kick
        cur = "R7";
        en = 1'b1;
        @(negedge clk); @(negedge clk);
        kick = 1'b0;
        @(negedge clk);
        kick = 1'b1;
        kick_at(2, 0, 1'b1, "R7");

        cur = "R3";
        kick_at(3, LO + 1, 1'b1, "R3");
        kick_at(3, HI - 1, 1'b1, "R3");
        cur = "R4";
        kick_at(3, LO, 1'b0, "R4");

        cur = "R9";
        toggle_for(2 * HI);
        @(negedge clk);
        chk(fault_n, 1'b0, "R9", "sticky fault_n_o");
        chk(fault_drv, 1'b1, "R10", "driven status");

        cur = "R6";
        en = 1'b0;
        @(negedge clk);
        chk(fault_n, 1'b1, "R6", "released on disable");
        toggle_for(2 * HI);
        @(negedge clk);
        chk(fault_n, 1'b1, "R6", "kicks ignored while disabled");

        cur = "R2";
        en = 1'b1;
        kick_at(2, HI - 1, 1'b1, "R2");
        cur = "R5";
        wait_count(3, HI);
        chk(fault_n, 1'b1, "R5", "no fault before upper bound");
        @(negedge clk);
        chk(fault_n, 1'b0, "R5", "timeout in window");

        cur = "R8";
        sup = 1'b1;
        @(negedge clk);
        chk(fault_n, 1'b1, "R8", "released by supervisor reset");
        toggle_for(2 * HI);
        @(negedge clk);
        chk(fault_n, 1'b1, "R8", "kicks ignored in supervisor reset");
        sup = 1'b0;

        cur = "R2";
        wait_count(2, HI);
        chk(fault_n, 1'b1, "R2", "first-kick before timeout");
        @(negedge clk);
        chk(fault_n, 1'b0, "R2", "first-kick timeout");

        cur = "R5";
        rearm();
        kick_at(2, 5, 1'b1, "R2");
        kick_at(3, HI, 1'b0, "R5");

        // R1: hold low, then a rising edge must not restart the window
        cur = "R1";
        rearm();
        wait_count(2, 3);
        kick = 1'b0;
        repeat (LO + 3) @(negedge clk);
        kick = 1'b1;
        wait_count(3, HI);
        @(negedge clk);
        chk(fault_n, 1'b0, "R1", "rising edge not a kick");

        // constrained random mix
        cur = "R3";
        rearm();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom % 24 == 0) kick = ~kick;
            if ($urandom % 700 == 0) en = ~en;
            if (!en && ($urandom % 8 == 0)) en = 1'b1;
            sup = ($urandom % 900 == 0) ? 1'b1 : (sup && ($urandom % 4 != 0));
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule